// File: doc/BRIEF.md
# Dual-Addend Multiply Execution Unit

This unit executes one unsigned multiply instruction that adds two separate 32-bit addends to a 32×32 product. It takes one instruction word and a mode input. With the mode low, the word is decoded as the 32-bit fixed-width form. With the mode high, the word is decoded as the two-halfword compact form, with the first halfword in bits 31:16 and the second in bits 15:0. The unit pulls out four register numbers and drives them as read addresses to a register file. It captures the four operands and forms `n*m + hi + lo` as a 64-bit value. It then writes the upper half back to the high destination and the lower half back to the low destination.

The worst case is `(2^32-1)^2 + 2*(2^32-1)`, which equals exactly `2^64-1`. The sum therefore always fits in 64 bits and has no carry out. The product is built over four cycles from 16-bit partial products. Every accepted instruction finishes in the same number of cycles, whatever its operands, its decode result or its condition outcome. Condition evaluation arrives already resolved, as one "condition passed" input.

Top module: `mul2add_exec`

## Requirements
- R1: For a matching encoding with the condition passed and distinct destinations, the unit writes result bits 63:32 to the high destination and bits 31:0 to the low destination, where result = n*m + hi + lo in unsigned 64-bit arithmetic on the captured operands.
- R2: With `t32_mode`=0 the word matches when bits 31:28 != 4'hF, bits 27:20 == 8'h04 and bits 7:4 == 4'h9. The fields are: high destination = bits 19:16, low destination = bits 15:12, multiplier m = bits 11:8, multiplicand n = bits 3:0.
- R3: With `t32_mode`=1 the word matches when bits 31:20 == 12'hFBE and bits 7:4 == 4'h6. The fields are: n = bits 19:16, low destination = bits 15:12, high destination = bits 11:8, m = bits 3:0.
- R4: A word that does not match raises `undef` together with `done`, and neither write enable is asserted.
- R5: A matching word in which any of the four register fields equals 15 raises `unpred` with `done`. The write still happens when R6 and R7 allow it.
- R6: A matching word whose high and low destination fields are equal raises `unpred` with `done` and executes as a no-op: no write enable is asserted.
- R7: When `cond_pass` is low at the accepted start, no write enable is asserted, and `done` still occurs.
- R8: `start` is accepted only while `busy` is low. `busy` is high from the cycle after acceptance until `done`. `done` is a one-cycle pulse exactly four cycles after the accepting edge, whatever the operands, decode result or condition.
- R9: `start` and any change to `insn`, `t32_mode`, `cond_pass` or the read data while `busy` is high have no effect on the running operation.
- R10: With all four operands equal to 32'hFFFFFFFF, the written pair is 64'hFFFFFFFF_FFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to execute `insn` |
| t32_mode | input | 1 | 0: 32-bit form, 1: two-halfword form |
| insn | input | 32 | Instruction word |
| cond_pass | input | 1 | Condition check already passed |
| ra_n | output | 4 | Read address, multiplicand |
| ra_m | output | 4 | Read address, multiplier |
| ra_hi | output | 4 | Read address, high addend/destination |
| ra_lo | output | 4 | Read address, low addend/destination |
| rd_n | input | 32 | Read data for `ra_n` |
| rd_m | input | 32 | Read data for `ra_m` |
| rd_hi | input | 32 | Read data for `ra_hi` |
| rd_lo | input | 32 | Read data for `ra_lo` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| undef | output | 1 | Non-matching encoding, valid with `done` |
| unpred | output | 1 | Unpredictable register choice, valid with `done` |
| we_hi | output | 1 | Write enable, high half |
| wa_hi | output | 4 | Write address, high half |
| wd_hi | output | 32 | Write data, result bits 63:32 |
| we_lo | output | 1 | Write enable, low half |
| wa_lo | output | 4 | Write address, low half |
| wd_lo | output | 32 | Write data, result bits 31:0 |

## Verification
The bench first runs every pair of destination fields in both forms. This exposes a unit that writes when the two destinations coincide, or that misses the field-15 flag. A unit that swaps fields between the two forms writes the wrong registers. The bench then runs a full cross of six boundary operand values, including all-ones, a lone top bit and half-word masks. A partial product shifted to the wrong place, or a lost carry between halves, shows up there as a wrong high word. Single-bit corruptions of every fixed opcode bit must each give `undef` with no write. Changing the inputs during `busy`, plus failed conditions, must leave both the four-cycle timing and the results unchanged.

// File: rtl/mul2add_exec.sv
module mul2add_exec #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            t32_mode,
  input  logic [31:0]     insn,
  input  logic            cond_pass,
  output logic [3:0]      ra_n,
  output logic [3:0]      ra_m,
  output logic [3:0]      ra_hi,
  output logic [3:0]      ra_lo,
  input  logic [XLEN-1:0] rd_n,
  input  logic [XLEN-1:0] rd_m,
  input  logic [XLEN-1:0] rd_hi,
  input  logic [XLEN-1:0] rd_lo,
  output logic            busy,
  output logic            done,
  output logic            undef,
  output logic            unpred,
  output logic            we_hi,
  output logic [3:0]      wa_hi,
  output logic [XLEN-1:0] wd_hi,
  output logic            we_lo,
  output logic [3:0]      wa_lo,
  output logic [XLEN-1:0] wd_lo
);
  localparam int H = XLEN / 2;
  localparam int W = 2 * XLEN;

  logic a_ok, t_ok, hit, take;
  logic [1:0] cnt;
  logic hit_q, cp_q, same_q, bad15_q;
  logic [XLEN-1:0] op_a, op_b;
  logic [W-1:0] acc, term, acc_nx;
  logic [H-1:0] pa, pb;
  logic [XLEN-1:0] pp;

  assign a_ok = (insn[31:28] != 4'hF) && (insn[27:20] == 8'h04) && (insn[7:4] == 4'h9);
  assign t_ok = (insn[31:20] == 12'hFBE) && (insn[7:4] == 4'h6);
  assign hit  = t32_mode ? t_ok : a_ok;

  assign ra_n  = t32_mode ? insn[19:16] : insn[3:0];
  assign ra_m  = t32_mode ? insn[3:0]   : insn[11:8];
  assign ra_hi = t32_mode ? insn[11:8]  : insn[19:16];
  assign ra_lo = insn[15:12];

  assign take = start && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= 2'd0;
      hit_q   <= 1'b0;
      cp_q    <= 1'b0;
      same_q  <= 1'b0;
      bad15_q <= 1'b0;
      wa_hi   <= 4'd0;
      wa_lo   <= 4'd0;
      op_a    <= '0;
      op_b    <= '0;
      acc     <= '0;
    end else if (take) begin
      busy    <= 1'b1;
      cnt     <= 2'd0;
      hit_q   <= hit;
      cp_q    <= cond_pass;
      same_q  <= (ra_hi == ra_lo);
      bad15_q <= (&ra_n) || (&ra_m) || (&ra_hi) || (&ra_lo);
      wa_hi   <= ra_hi;
      wa_lo   <= ra_lo;
      op_a    <= rd_n;
      op_b    <= rd_m;
      acc     <= {{XLEN{1'b0}}, rd_hi} + {{XLEN{1'b0}}, rd_lo};
    end else if (busy) begin
      cnt <= cnt + 2'd1;
      acc <= acc_nx;
      if (cnt == 2'd3) busy <= 1'b0;
    end
  end

  assign pa = cnt[1] ? op_a[XLEN-1:H] : op_a[H-1:0];
  assign pb = cnt[0] ? op_b[XLEN-1:H] : op_b[H-1:0];
  assign pp = {{H{1'b0}}, pa} * {{H{1'b0}}, pb};

  always_comb begin
    case (cnt)
      2'd0:    term = {{XLEN{1'b0}}, pp};
      2'd3:    term = {pp, {XLEN{1'b0}}};
      default: term = {{H{1'b0}}, pp, {H{1'b0}}};
    endcase
  end

  assign acc_nx = acc + term;

  assign done   = busy && (cnt == 2'd3);
  assign undef  = done && !hit_q;
  assign unpred = done && hit_q && (same_q || bad15_q);
  assign we_hi  = done && hit_q && cp_q && !same_q;
  assign we_lo  = we_hi;
  assign wd_hi  = acc_nx[W-1:XLEN];
  assign wd_lo  = acc_nx[XLEN-1:0];
endmodule

module mul2add_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       undef,
  input logic       unpred,
  input logic       we_hi,
  input logic       we_lo,
  input logic [3:0] wa_hi,
  input logic [3:0] wa_lo
);
  // R8
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |-> ##4 done);
  // R8
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  // R4
  undef_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> (!we_hi && !we_lo));
  // R6
  distinct_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_hi |-> (wa_hi != wa_lo));
  // R5
  unpred_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unpred |-> (done && !undef));
endmodule

bind mul2add_exec mul2add_chk u_chk (.*);

// File: tb/test_mul2add_exec.sv
`timescale 1ns/1ps
module test_mul2add_exec;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, start, t32_mode, cond_pass;
  logic [31:0] insn;
  logic [3:0] ra_n, ra_m, ra_hi, ra_lo, wa_hi, wa_lo;
  logic [31:0] rd_n, rd_m, rd_hi, rd_lo, wd_hi, wd_lo;
  logic busy, done, undef, unpred, we_hi, we_lo;

  logic [31:0] rf [16];
  assign rd_n  = rf[ra_n];
  assign rd_m  = rf[ra_m];
  assign rd_hi = rf[ra_hi];
  assign rd_lo = rf[ra_lo];

  mul2add_exec i_mul2add_exec (.*);

  int nchk = 0, nbad = 0;
  logic [63:0] last_wd;
  logic [31:0] seed = 32'h1234_5678;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: got %h exp %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic logic [31:0] enc_a(input logic [3:0] c, h, l, m, n);
    return {c, 8'h04, h, l, m, 4'h9, n};
  endfunction

  function automatic logic [31:0] enc_t(input logic [3:0] n, l, h, m);
    return {12'hFBE, n, l, h, 4'h6, m};
  endfunction

  task automatic op(input bit t, input logic [31:0] iw, input bit cp, input bit xu,
                    input logic [3:0] fh, fl, fn, fm, input bit poke, input string tag);
    logic [63:0] res;
    bit same, b15, xwe, xunp;
    @(negedge clk);
    t32_mode = t; insn = iw; cond_pass = cp; start = 1'b1;
    res  = 64'(rf[fn]) * 64'(rf[fm]) + 64'(rf[fh]) + 64'(rf[fl]);
    same = (fh == fl);
    b15  = (fh == 4'hF) || (fl == 4'hF) || (fn == 4'hF) || (fm == 4'hF);
    xwe  = !xu && cp && !same;
    xunp = !xu && (same || b15);
    @(posedge clk); @(negedge clk);
    if (poke) begin
      insn = ~iw; t32_mode = ~t; cond_pass = ~cp;
      for (int i = 0; i < 16; i++) rf[i] = ~rf[i];
    end else start = 1'b0;
    chk(busy == 1'b1, "R8", "busy after accept", 64'(busy), 64'd1);
    @(posedge clk); @(negedge clk);
    chk(done == 1'b0, "R8", "early done c1", 64'(done), 64'd0);
    @(posedge clk); @(negedge clk);
    chk(done == 1'b0, "R8", "early done c2", 64'(done), 64'd0);
    start = 1'b0;
    if (poke) for (int i = 0; i < 16; i++) rf[i] = ~rf[i];
    @(posedge clk); @(negedge clk);
    chk(done == 1'b1, "R8", "done on 4th cycle", 64'(done), 64'd1);
    chk(undef == xu, xu ? "R4" : tag, "undef", 64'(undef), 64'(xu));
    chk(unpred == xunp, same ? "R6" : "R5", "unpred", 64'(unpred), 64'(xunp));
    chk(we_hi == xwe, cp ? "R6" : "R7", "we_hi", 64'(we_hi), 64'(xwe));
    chk(we_lo == xwe, cp ? "R6" : "R7", "we_lo", 64'(we_lo), 64'(xwe));
    if (xwe) begin
      chk(wa_hi == fh, tag, "wa_hi", 64'(wa_hi), 64'(fh));
      chk(wa_lo == fl, tag, "wa_lo", 64'(wa_lo), 64'(fl));
      chk({wd_hi, wd_lo} == res, poke ? "R9" : "R1", "result", {wd_hi, wd_lo}, res);
      last_wd = {wd_hi, wd_lo};
    end
    if (we_hi) rf[wa_hi] = wd_hi;
    if (we_lo) rf[wa_lo] = wd_lo;
    @(posedge clk); @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R8", "idle after done", {busy, done}, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: got timeout exp finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    logic [31:0] cv [6];
    cv[0] = 32'h0; cv[1] = 32'h1; cv[2] = 32'hFFFF_FFFF;
    cv[3] = 32'h8000_0000; cv[4] = 32'h0000_FFFF; cv[5] = 32'hFFFF_0000;
    for (int i = 0; i < 16; i++) rf[i] = rnd();
    rst_n = 1'b0; start = 1'b0; t32_mode = 1'b0; cond_pass = 1'b0; insn = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy == 0 && done == 0 && we_hi == 0 && we_lo == 0, "R8", "reset state",
        {busy, done, we_hi, we_lo}, 64'd0);
    rst_n = 1'b1;

    // R2 / R3 / R5 / R6: every destination pair in both forms
    for (int h = 0; h < 16; h++)
      for (int l = 0; l < 16; l++) begin
        logic [3:0] n, m;
        n = 4'(h + 3); m = 4'(l + 7);
        op(1'b0, enc_a(4'(h % 15), 4'(h), 4'(l), m, n), 1'b1, 1'b0,
           4'(h), 4'(l), n, m, 1'b0, "R2");
        op(1'b1, enc_t(n, 4'(l), 4'(h), m), 1'b1, 1'b0,
           4'(h), 4'(l), n, m, 1'b0, "R3");
      end

    // R1: cross of boundary operand values
    for (int a = 0; a < 6; a++)
      for (int b = 0; b < 6; b++)
        for (int c = 0; c < 6; c++)
          for (int d = 0; d < 6; d++) begin
            rf[3] = cv[a]; rf[4] = cv[b]; rf[1] = cv[c]; rf[2] = cv[d];
            if ((a + b + c + d) % 2 == 0)
              op(1'b0, enc_a(4'hE, 4'd1, 4'd2, 4'd4, 4'd3), 1'b1, 1'b0,
                 4'd1, 4'd2, 4'd3, 4'd4, 1'b0, "R1");
            else
              op(1'b1, enc_t(4'd3, 4'd2, 4'd1, 4'd4), 1'b1, 1'b0,
                 4'd1, 4'd2, 4'd3, 4'd4, 1'b0, "R1");
          end

    // R10: all-ones worst case
    rf[5] = '1; rf[6] = '1; rf[7] = '1; rf[8] = '1;
    op(1'b0, enc_a(4'h0, 4'd5, 4'd6, 4'd8, 4'd7), 1'b1, 1'b0,
       4'd5, 4'd6, 4'd7, 4'd8, 1'b0, "R10");
    chk(last_wd == 64'hFFFF_FFFF_FFFF_FFFF, "R10", "max result", last_wd, 64'hFFFF_FFFF_FFFF_FFFF);

    // R4: every fixed opcode bit corrupted, both forms, plus forbidden condition
    for (int b = 0; b < 32; b++) begin
      if ((b >= 20 && b <= 27) || (b >= 4 && b <= 7))
        op(1'b0, enc_a(4'hE, 4'd1, 4'd2, 4'd3, 4'd4) ^ (32'd1 << b), 1'b1, 1'b1,
           4'd1, 4'd2, 4'd4, 4'd3, 1'b0, "R4");
      if (b >= 20 || (b >= 4 && b <= 7))
        op(1'b1, enc_t(4'd4, 4'd2, 4'd1, 4'd3) ^ (32'd1 << b), 1'b1, 1'b1,
           4'd1, 4'd2, 4'd4, 4'd3, 1'b0, "R4");
    end
    op(1'b0, enc_a(4'hF, 4'd1, 4'd2, 4'd3, 4'd4), 1'b1, 1'b1, 4'd1, 4'd2, 4'd4, 4'd3, 1'b0, "R4");
    op(1'b1, enc_a(4'hE, 4'd1, 4'd2, 4'd3, 4'd4), 1'b1, 1'b1, 4'd1, 4'd2, 4'd4, 4'd3, 1'b0, "R4");
    op(1'b0, enc_t(4'd4, 4'd2, 4'd1, 4'd3), 1'b1, 1'b1, 4'd1, 4'd2, 4'd4, 4'd3, 1'b0, "R4");

    // R7 / R9 / R1: random operands, failed conditions, input changes while busy
    for (int k = 0; k < 300; k++) begin
      logic [31:0] r;
      logic [3:0] h, l, n, m;
      r = rnd();
      h = r[3:0]; l = r[7:4]; n = r[11:8]; m = r[15:12];
      rf[n] = rnd(); rf[m] = rnd(); rf[h] = rnd(); rf[l] = rnd();
      if (r[16])
        op(1'b1, enc_t(n, l, h, m), !(r[18:17] == 2'b00), 1'b0, h, l, n, m, r[19],
           r[19] ? "R9" : "R7");
      else
        op(1'b0, enc_a(4'(r[23:20] % 15), h, l, m, n), !(r[18:17] == 2'b00), 1'b0,
           h, l, n, m, r[19], r[19] ? "R9" : "R7");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule